// File: doc/BRIEF.md
# BCD Calendar Clock with Byte-Wide Holding Registers

This block keeps the time of day and the calendar in packed BCD: century, year, month, date, day of week, hour (24-hour form), minute and second. A clock-enable input carries pulses from a prescaler. After a set number of those pulses, the calendar takes one second step. Each carry ripples through every field up to the century within that step. Month lengths of 28, 29, 30 and 31 days are applied without help from software. A year is taken as a leap year when it is divisible by four.

Software never touches the live counters. It works on eight byte-wide holding copies and one control byte. These sit in the top sixteen bytes of a byte-addressed space and are reached with a plain read/write bus cycle. The holding copies are reloaded from the counters on every second step, unless the control byte suspends that reload. One control bit freezes the copies so that several bytes can be read as one consistent snapshot. Another control bit lets software write new values, which go into the counters when that bit is cleared. The low six bits of the control byte hold a signed trim that stretches or shortens one second in every minute.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the holding bytes read century 0x20, year 0x00, month 0x01, date 0x01, day 0x01, hour 0x00, minute 0x00, second 0x00, and the control byte reads 0x00.
- R2: A second step happens on the TICKS_PER_SEC-th `tick_en` pulse after the previous step or after a load. While `tick_en` is low, the time does not advance. Each step copies the new time into the holding bytes, unless that copy is suspended.
- R3: Seconds and minutes wrap from 0x59 to 0x00, and hours wrap from 0x23 to 0x00. A carry out of the hours advances the date and the day of week, and the day of week wraps from 0x07 to 0x01.
- R4: The date wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in all other months except February. The month then advances.
- R5: In February the date wraps after 0x29 when the BCD year is divisible by four (including year 0x00), and after 0x28 otherwise.
- R6: After month 0x12 date 0x31, the month returns to 0x01 and the year advances. After year 0x99 the year returns to 0x00 and the century advances, all within the same step.
- R7: While control bit 6 is 1, the holding bytes keep their values across second steps, and counting goes on internally. After the bit is cleared, the next step shows the advanced time.
- R8: While control bit 7 is 1, the reload is suspended and bytes written by software stay as written. A control write that takes bit 7 from 1 to 0 copies all holding bytes into the counters and restarts the one-second prescaler.
- R9: Control bit 5 is the trim sign (1 = shorten, 0 = lengthen) and bits 4:0 are the trim magnitude. Only the second that starts at second 0x59 lasts TICKS_PER_SEC plus or minus the magnitude in `tick_en` pulses. All other seconds are unchanged.
- R10: Reads outside the window, and reads of the unused window offsets 0x2 to 0x7 and 0x0, return 0x00. Writes there change nothing. The full address is decoded, so addresses that alias in the low four bits do not reach the window.
- R11: The window occupies the top 16 bytes of the address space. Offset 0x1 holds the century and offset 0x8 the control byte. Offsets 0x9 through 0xF hold second, minute, hour, day of week, date, month and year. The control byte reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled clock enable, one pulse per sub-second tick |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address during a read |

## Verification
Each test loads a start time through the write bit and lets one second step pass. The start times are chosen so that each one isolates a different carry path:
- 23:59:59 with day 7, where the carry reaches the day-of-week wrap.
- The ends of 30-day and 31-day months, which separate the month-length table.
- February 28 and 29 in leap and non-leap years, plus year 00, which separate the leap rule.
- The ends of year 2023 and year 2099, where the carry reaches the year and the century.

A second group of patterns drives the timing. Holding `tick_en` low shows that only enable pulses are counted. Trim values of both signs are checked against the 58th second, so a trim applied to the wrong second is caught as well as a trim with the wrong sign. A read taken between the old and the restarted prescaler phase shows whether a load restarts the prescaler.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   localparam int NUM_SLOTS = 8;
   localparam int CAL_W     = 5;

   typedef struct packed {
      logic [7:0] cen;
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] dat;
      logic [7:0] dow;
      logic [7:0] hr;
      logic [7:0] mn;
      logic [7:0] sc;
   } rtc_time_t;

   localparam rtc_time_t RTC_RST = '{cen: 8'h20, yr: 8'h00, mon: 8'h01, dat: 8'h01,
                                     dow: 8'h01, hr: 8'h00, mn: 8'h00, sc: 8'h00};

   // BCD increment that wraps to 'first' at or beyond 'last'
   function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] last,
                                           input logic [7:0] first);
      if (v >= last)            return first;
      else if (v[3:0] >= 4'h9)  return {v[7:4] + 4'h1, 4'h0};
      else                      return v + 8'h01;
   endfunction

   // BCD year divisible by four
   function automatic logic bcd_leap(input logic [7:0] y);
      case (y[3:0])
         4'h0, 4'h4, 4'h8: return ~y[4];
         4'h2, 4'h6:       return y[4];
         default:          return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] bcd_last_date(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
   parameter int TICKS_PER_SEC = 64,
   parameter int CAL_W         = 5,
   parameter bit CAL_EN        = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             restart,
   input  logic             trim_now,
   input  logic             trim_neg,
   input  logic [CAL_W-1:0] trim_mag,
   output logic             sec_pulse
);
   localparam int CNT_W = $clog2(TICKS_PER_SEC + (1 << CAL_W));
   localparam logic [CNT_W-1:0] BASE = CNT_W'(TICKS_PER_SEC - 1);

   initial begin
      assert (TICKS_PER_SEC > (1 << CAL_W))
         else $error("TICKS_PER_SEC must exceed the largest trim magnitude");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   generate
      if (CAL_EN) begin : g_trim
         always_comb begin
            if (!trim_now)     limit = BASE;
            else if (trim_neg) limit = BASE - CNT_W'(trim_mag);
            else               limit = BASE + CNT_W'(trim_mag);
         end
      end else begin : g_fixed
         assign limit = BASE;
      end
   endgenerate

   assign sec_pulse = tick_en && (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart)    cnt_q <= '0;
      else if (tick_en)    cnt_q <= sec_pulse ? '0 : cnt_q + 1'b1;
   end

   AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !sec_pulse); // R2
   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sec_pulse); // R8

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
   import bcd_rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t now_t,
   output rtc_time_t next_t
);
   logic       c_mn, c_hr, c_day, c_mon, c_yr, c_cen;
   logic [7:0] dlast;

   // full carry chain from seconds to century in one step
   always_comb begin
      next_t = now_t;
      dlast  = bcd_last_date(now_t.mon, now_t.yr);
      c_mn   = now_t.sc >= 8'h59;
      c_hr   = c_mn  && now_t.mn  >= 8'h59;
      c_day  = c_hr  && now_t.hr  >= 8'h23;
      c_mon  = c_day && now_t.dat >= dlast;
      c_yr   = c_mon && now_t.mon >= 8'h12;
      c_cen  = c_yr  && now_t.yr  >= 8'h99;
      next_t.sc = bcd_step(now_t.sc, 8'h59, 8'h00);
      if (c_mn)  next_t.mn  = bcd_step(now_t.mn, 8'h59, 8'h00);
      if (c_hr)  next_t.hr  = bcd_step(now_t.hr, 8'h23, 8'h00);
      if (c_day) begin
         next_t.dow = bcd_step(now_t.dow, 8'h07, 8'h01);
         next_t.dat = bcd_step(now_t.dat, dlast, 8'h01);
      end
      if (c_mon) next_t.mon = bcd_step(now_t.mon, 8'h12, 8'h01);
      if (c_yr)  next_t.yr  = bcd_step(now_t.yr, 8'h99, 8'h00);
      if (c_cen) next_t.cen = bcd_step(now_t.cen, 8'h99, 8'h00);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     now_t <= RTC_RST;
      else if (load)  now_t <= load_val;
      else if (step)  now_t <= next_t;
   end

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !load |=> $stable(now_t)); // R2
   AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> now_t == $past(load_val)); // R8
   AST_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && now_t.hr == 8'h23 && now_t.mn == 8'h59 && now_t.sc == 8'h59
      |=> now_t.hr == 8'h00 && now_t.dow != $past(now_t.dow)); // R3

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
   import bcd_rtc_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              step,
   input  rtc_time_t         next_t,
   output rtc_time_t         hold_t,
   output logic              load,
   output logic              trim_neg,
   output logic [CAL_W-1:0]  trim_mag
);
   localparam logic [3:0] CTRL_OFS = 4'h8;
   localparam logic [3:0] CEN_OFS  = 4'h1;
   localparam logic [3:0] SEC_OFS  = 4'h9;
   localparam logic [8*NUM_SLOTS-1:0] RST_V = RTC_RST;

   initial begin
      assert (ADDR_W >= 5) else $error("ADDR_W too small for the register window");
   end

   logic                   in_win, wr, freeze, ctrl_hit;
   logic [3:0]             ofs;
   logic [7:0]             ctrl_q;
   logic [NUM_SLOTS-1:0]   hit;
   logic [8*NUM_SLOTS-1:0] hold_v;

   assign in_win   = &bus_addr[ADDR_W-1:4];
   assign ofs      = bus_addr[3:0];
   assign wr       = bus_sel && bus_we && in_win;
   assign ctrl_hit = in_win && ofs == CTRL_OFS;
   assign freeze   = ctrl_q[7] | ctrl_q[6];

   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
         localparam logic [3:0] OFS = (i == NUM_SLOTS - 1) ? CEN_OFS : 4'(SEC_OFS + i);
         logic [7:0] byte_q;
         assign hit[i] = in_win && ofs == OFS;
         always_ff @(posedge clk) begin
            if (!rst_n)                 byte_q <= RST_V[i*8 +: 8];
            else if (wr && hit[i])      byte_q <= bus_wdata;
            else if (step && !freeze)   byte_q <= next_t[i*8 +: 8];
         end
         assign hold_v[i*8 +: 8] = byte_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)               ctrl_q <= '0;
      else if (wr && ctrl_hit)  ctrl_q <= bus_wdata;
   end

   assign load     = wr && ctrl_hit && ctrl_q[7] && !bus_wdata[7];
   assign hold_t   = rtc_time_t'(hold_v);
   assign trim_neg = ctrl_q[5];
   assign trim_mag = ctrl_q[CAL_W-1:0];

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_sel && !bus_we) begin
         if (ctrl_hit) bus_rdata = ctrl_q;
         for (int k = 0; k < NUM_SLOTS; k++)
            if (hit[k]) bus_rdata = hold_v[k*8 +: 8];
      end
   end

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      freeze && !wr |=> $stable(hold_v)); // R7
   AST_REFRESH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      step && !freeze && !wr |=> hold_v == $past(next_t)); // R2

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
   import bcd_rtc_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int TICKS_PER_SEC = 64,
   parameter bit CAL_EN        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);
   rtc_time_t        now_t, next_t, hold_t;
   logic             sec_pulse, load, trim_neg;
   logic [CAL_W-1:0] trim_mag;

   bcd_rtc_prescaler #(
      .TICKS_PER_SEC (TICKS_PER_SEC),
      .CAL_W         (CAL_W),
      .CAL_EN        (CAL_EN)
   ) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .restart   (load),
      .trim_now  (now_t.sc == 8'h59),
      .trim_neg  (trim_neg),
      .trim_mag  (trim_mag),
      .sec_pulse (sec_pulse)
   );

   bcd_rtc_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (sec_pulse),
      .load     (load),
      .load_val (hold_t),
      .now_t    (now_t),
      .next_t   (next_t)
   );

   bcd_rtc_regs #(
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .step      (sec_pulse),
      .next_t    (next_t),
      .hold_t    (hold_t),
      .load      (load),
      .trim_neg  (trim_neg),
      .trim_mag  (trim_mag)
   );

endmodule

// File: tb/bcd_rtc_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_tb_top;
   localparam int AW = 15;
   localparam logic [AW-1:0] A_CEN = 15'h7FF1, A_CTL = 15'h7FF8, A_SEC = 15'h7FF9,
                             A_MIN = 15'h7FFA, A_HR  = 15'h7FFB, A_DOW = 15'h7FFC,
                             A_DAT = 15'h7FFD, A_MON = 15'h7FFE, A_YR  = 15'h7FFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   typedef struct {
      logic [AW-1:0] a;
      logic [7:0]    d;
      string         req;
   } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bcd_rtc #(.ADDR_W(AW), .TICKS_PER_SEC(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   // monitor: pop expected item and compare against the read data
   always @(negedge clk) begin
      if (bus_sel && !bus_we) begin
         exp_t e;
         e = exp_q.pop_front();
         n_chk++;
         if (bus_rdata !== e.d) begin
            n_fail++;
            $display("FAIL %s addr %h actual %h expected %h", e.req, e.a, bus_rdata, e.d);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [7:0] d, input string req);
      exp_t e;
      @(posedge clk); #1;
      e.a = a; e.d = d; e.req = req;
      exp_q.push_back(e);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) begin @(posedge clk); #1; end
   endtask

   // read the state present after clock edge n
   task automatic rd_at(input int n, input logic [AW-1:0] a, input logic [7:0] d,
                        input string req);
      wait_cyc(n - 1);
      rd(a, d, req);
   endtask

   task automatic set_time(input logic [7:0] cen, yr, mon, dat, dow, hr, mn, sc,
                           input logic [7:0] ctl, output int t0);
      wr(A_CTL, 8'h80);
      wr(A_CEN, cen); wr(A_YR, yr); wr(A_MON, mon); wr(A_DAT, dat);
      wr(A_DOW, dow); wr(A_HR, hr); wr(A_MIN, mn); wr(A_SEC, sc);
      wr(A_CTL, ctl);
      t0 = cyc;
   endtask

   task automatic chk_all(input int t0, input logic [7:0] cen, yr, mon, dat, dow, hr, mn, sc,
                          input string req);
      wait_cyc(t0 + 66);
      rd(A_SEC, sc, req); rd(A_MIN, mn, req); rd(A_HR, hr, req); rd(A_DOW, dow, req);
      rd(A_DAT, dat, req); rd(A_MON, mon, req); rd(A_YR, yr, req); rd(A_CEN, cen, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int t0, t1;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values, R11 map
      rd(A_CEN, 8'h20, "R1"); rd(A_YR, 8'h00, "R1"); rd(A_MON, 8'h01, "R1");
      rd(A_DAT, 8'h01, "R1"); rd(A_DOW, 8'h01, "R1"); rd(A_HR, 8'h00, "R1");
      rd(A_MIN, 8'h00, "R1"); rd(A_SEC, 8'h00, "R1"); rd(A_CTL, 8'h00, "R1");
      // R10 reserved offsets and aliases
      wr(15'h7FF3, 8'hAA);
      wr(15'h3FF9, 8'h77);
      rd(15'h7FF3, 8'h00, "R10");
      rd(15'h7FF0, 8'h00, "R10");
      rd(A_SEC, 8'h00, "R10");
      rd(15'h3FF9, 8'h00, "R10");

      // R3 midnight with day-of-week wrap, R8 load visible
      set_time(8'h20, 8'h23, 8'h06, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      rd_at(t0 + 20, A_SEC, 8'h59, "R8");
      rd_at(t0 + 60, A_SEC, 8'h59, "R2");
      chk_all(t0, 8'h20, 8'h23, 8'h06, 8'h16, 8'h01, 8'h00, 8'h00, 8'h00, "R3");

      // R2 tick_en low halts counting
      set_time(8'h20, 8'h24, 8'h03, 8'h10, 8'h02, 8'h10, 8'h20, 8'h30, 8'h00, t0);
      tick_en = 1'b0;
      wait_cyc(t0 + 100);
      tick_en = 1'b1;
      rd_at(t0 + 160, A_SEC, 8'h30, "R2");
      rd_at(t0 + 170, A_SEC, 8'h31, "R2");

      // R4 month lengths
      set_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h20, 8'h24, 8'h05, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00, "R4");
      set_time(8'h20, 8'h24, 8'h05, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h20, 8'h24, 8'h05, 8'h31, 8'h05, 8'h00, 8'h00, 8'h00, "R4");
      set_time(8'h20, 8'h24, 8'h01, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h20, 8'h24, 8'h02, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, "R4");

      // R5 February, leap and non-leap
      set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h20, 8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, "R5");
      set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00, "R5");
      set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h20, 8'h24, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00, "R5");
      set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h21, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00, "R5");

      // R6 year and century carry
      set_time(8'h20, 8'h23, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h20, 8'h24, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R6");
      set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59, 8'h00, t0);
      chk_all(t0, 8'h21, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, "R6");

      // R7 read freeze
      set_time(8'h20, 8'h24, 8'h07, 8'h04, 8'h04, 8'h12, 8'h00, 8'h00, 8'h00, t0);
      wr(A_CTL, 8'h40);
      rd_at(t0 + 200, A_SEC, 8'h00, "R7");
      rd(A_CTL, 8'h40, "R11");
      wr(A_CTL, 8'h00);
      rd_at(t0 + 266, A_SEC, 8'h04, "R7");

      // R8 write bit: suspended refresh, load, prescaler restart
      set_time(8'h20, 8'h24, 8'h08, 8'h01, 8'h04, 8'h08, 8'h00, 8'h00, 8'h00, t0);
      wr(A_CTL, 8'h80);
      wr(A_SEC, 8'h30);
      wr(A_MIN, 8'h45);
      rd_at(t0 + 140, A_SEC, 8'h30, "R8");
      rd(A_MIN, 8'h45, "R8");
      wr(A_CTL, 8'h00);
      t1 = cyc;
      rd_at(t1 + 55, A_SEC, 8'h30, "R8");
      rd_at(t1 + 70, A_SEC, 8'h31, "R8");
      rd(A_MIN, 8'h45, "R8");
      rd(A_HR, 8'h08, "R8");

      // R9 lengthened minute-end second
      set_time(8'h20, 8'h24, 8'h09, 8'h01, 8'h07, 8'h10, 8'h15, 8'h58, 8'h0A, t0);
      rd_at(t0 + 70, A_SEC, 8'h59, "R9");
      rd_at(t0 + 132, A_SEC, 8'h59, "R9");
      rd_at(t0 + 142, A_SEC, 8'h00, "R9");
      rd(A_MIN, 8'h16, "R9");
      rd(A_CTL, 8'h0A, "R11");
      // R9 shortened minute-end second
      set_time(8'h20, 8'h24, 8'h09, 8'h01, 8'h07, 8'h10, 8'h15, 8'h58, 8'h2A, t0);
      rd_at(t0 + 60, A_SEC, 8'h58, "R9");
      rd_at(t0 + 100, A_SEC, 8'h59, "R9");
      rd_at(t0 + 122, A_SEC, 8'h00, "R9");
      rd(A_CTL, 8'h2A, "R11");

      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule